// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each virtual address presented by a load/store pipeline into one of three outcomes: a direct physical translation with its cacheable attribute, a translation that must come from the TLB, or an exception. A mode input picks between a 32-bit compatibility map and a full 64-bit map. In the 32-bit map only the low word of the address is decoded. In the 64-bit map the top 24 bits choose the region, and an 11-bit sub-field refines the all-ones region.

A mapped address raises `tlb_req` in the same cycle so that an external TLB can answer on `tlb_hit`, `tlb_paddr` and `tlb_cached` within that cycle. One cycle after a request the block presents a registered response: the page-aligned physical address, the cached attribute, a fault flag and, for real accesses, an exception strobe with its cause code. The faulting address is also loaded into a bad-address register. A probe that only asks about a translation still learns whether it failed, but it leaves the exception outputs and the bad-address register untouched.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: After a synchronous reset, `rsp_valid` and `exc_valid` are 0 and `bad_vaddr` is 0.
- R2: With `mode64`=0, zones `vaddr[31:29]` of 0, 1, 2, 3, 6 and 7 assert `tlb_req` in the request cycle. On a TLB hit the response carries `tlb_paddr` with bits [11:0] cleared, `tlb_cached` as the cached flag, and `rsp_mapped`=1. Bits [63:32] of the address have no effect.
- R3: With `mode64`=0, zone 4 gives `{vaddr[28:12],12'h000}` with cached=1 and zone 5 gives the same address with cached=0. Neither zone asserts `tlb_req`.
- R4: With `mode64`=1, a region `vaddr[63:40]` of 0x000000, 0x400000 or 0xC00000, and region 0xFFFFFF with sub-zone `vaddr[39:29]` of 0x7FE or 0x7FF, take the TLB path as in R2.
- R5: With `mode64`=1, region 0xFFFFFF with sub-zone 0x7FC gives `{vaddr[28:12],12'h000}` cached, and sub-zone 0x7FD gives the same address uncached.
- R6: With `mode64`=1, regions 0x800000, 0x880000, 0x900000, 0x980000, 0xA00000, 0xA80000, 0xB00000 and 0xB80000 translate directly. The physical address is `vaddr[PA_W-1:12]` followed by 12 zero bits, and the access is uncached only when `vaddr[60:59]` equals 2.
- R7: With `mode64`=1, any other region, or a sub-zone under 0xFFFFFF other than 0x7FC to 0x7FF, sets `rsp_fault`. The cause is 4 for a read and 5 for a write. `exc_cause` is 0 in any response without an exception.
- R8: A TLB miss on a TLB-path address sets `rsp_fault`, with cause 2 for a read and 3 for a write.
- R9: When `exc_valid` is 1, `bad_vaddr` holds the full 64-bit faulting address. When no exception is raised, `bad_vaddr` keeps its value.
- R10: With `probe_only`=1, a failing request still sets `rsp_fault`, but `exc_valid` stays 0 and `bad_vaddr` is unchanged.
- R11: Every response appears as a one-cycle `rsp_valid` pulse exactly one cycle after its `req_valid`. Requests may come back-to-back. Idle cycles produce no response.
- R12: A faulting response reports physical address 0 and cached=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode64 | input | 1 | 1 selects the 64-bit map, 0 the 32-bit map |
| vaddr | input | 64 | Virtual address |
| is_write | input | 1 | 1 for a store, 0 for a load |
| probe_only | input | 1 | Translation probe; suppresses exceptions |
| tlb_hit | input | 1 | TLB result: match found |
| tlb_paddr | input | PA_W | TLB result: physical address |
| tlb_cached | input | 1 | TLB result: cacheable |
| tlb_req | output | 1 | Combinational request for a TLB lookup |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_mapped | output | 1 | Response came through the TLB path |
| rsp_paddr | output | PA_W | Page-aligned physical address |
| rsp_cached | output | 1 | Cacheable attribute |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 5 | Exception cause code |
| bad_vaddr | output | 64 | Last faulting virtual address |

## Verification
The bench builds the block with the default `PA_W` of 36, `PAGE_BITS` of 12 and a cache-attribute field at bit 59. At that width, direct-window addresses whose bits 35 to 29 are set, and whose bits above 35 carry junk, show both that the physical mask keeps exactly 36 bits and that the translation does not stop at the 29 bits the unmapped windows use. The bench also drives look-alike regions next to the direct-window values and sub-zones just below 0x7FC, which separates the address-error path from its neighbours.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        SEG_DIRECT  = 2'd0,
        SEG_MAPPED  = 2'd1,
        SEG_BADADDR = 2'd2
    } seg_kind_e;

    typedef struct packed {
        seg_kind_e   kind;
        logic        cached;
        logic [63:0] paddr;
    } seg_route_t;

    typedef enum logic [4:0] {
        CAUSE_NONE   = 5'd0,
        CAUSE_TLB_LD = 5'd2,
        CAUSE_TLB_ST = 5'd3,
        CAUSE_ADR_LD = 5'd4,
        CAUSE_ADR_ST = 5'd5
    } cause_e;

    // Clear the in-page offset bits.
    function automatic logic [63:0] clr_page(input logic [63:0] a, input int unsigned pb);
        return a & ~((64'd1 << pb) - 64'd1);
    endfunction

    function automatic cause_e fault_cause(input logic tlb_miss, input logic wr);
        if (tlb_miss) return wr ? CAUSE_TLB_ST : CAUSE_TLB_LD;
        return wr ? CAUSE_ADR_ST : CAUSE_ADR_LD;
    endfunction

endpackage

// File: rtl/seg_class32.sv
module seg_class32
    import vsd_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic [31:0] va,
    output seg_route_t  route
);
    localparam int UNMAP_BITS = 29;

    logic [2:0] zone;
    assign zone = va[31:29];

    always_comb begin
        route.kind   = SEG_MAPPED;
        route.cached = 1'b0;
        route.paddr  = '0;
        if (zone == 3'd4 || zone == 3'd5) begin
            route.kind   = SEG_DIRECT;
            route.cached = (zone == 3'd4);
            route.paddr  = clr_page({{(64-UNMAP_BITS){1'b0}}, va[UNMAP_BITS-1:0]}, PAGE_BITS);
        end
    end
endmodule

// File: rtl/seg_class64.sv
module seg_class64
    import vsd_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 36,
    parameter int CCA_LSB   = 59
) (
    input  logic [63:0] va,
    output seg_route_t  route
);
    localparam int          UNMAP_BITS = 29;
    localparam logic [63:0] PA_MASK    = {{(64-PA_W){1'b0}}, {PA_W{1'b1}}};
    localparam logic [1:0]  CCA_UNCACH = 2'd2;

    logic [23:0] region;
    logic [10:0] sub;
    logic        phys_win;

    assign region   = va[63:40];
    assign sub      = va[39:29];
    // 0x80..0xB8 in steps of 8 in the top byte, rest zero
    assign phys_win = (region[23:22] == 2'b10) && (region[18:0] == '0);

    always_comb begin
        route.kind   = SEG_BADADDR;
        route.cached = 1'b0;
        route.paddr  = '0;
        if (region == 24'h000000 || region == 24'h400000 || region == 24'hC00000) begin
            route.kind = SEG_MAPPED;
        end else if (region == 24'hFFFFFF) begin
            case (sub)
                11'h7FC, 11'h7FD: begin
                    route.kind   = SEG_DIRECT;
                    route.cached = (sub == 11'h7FC);
                    route.paddr  = clr_page({{(64-UNMAP_BITS){1'b0}}, va[UNMAP_BITS-1:0]}, PAGE_BITS);
                end
                11'h7FE, 11'h7FF: route.kind = SEG_MAPPED;
                default:          route.kind = SEG_BADADDR;
            endcase
        end else if (phys_win) begin
            route.kind   = SEG_DIRECT;
            route.cached = (va[CCA_LSB+1:CCA_LSB] != CCA_UNCACH);
            route.paddr  = clr_page(va & PA_MASK, PAGE_BITS);
        end
    end
endmodule

// File: rtl/seg_outreg.sv
module seg_outreg
    import vsd_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            fault_i,
    input  logic            mapped_i,
    input  logic            cached_i,
    input  logic [PA_W-1:0] paddr_i,
    input  logic            raise_i,
    input  cause_e          cause_i,
    input  logic [63:0]     va_i,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic            rsp_mapped,
    output logic            rsp_cached,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            exc_valid,
    output logic [4:0]      exc_cause,
    output logic [63:0]     bad_vaddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_mapped <= 1'b0;
            rsp_cached <= 1'b0;
            rsp_paddr  <= '0;
            exc_valid  <= 1'b0;
            exc_cause  <= CAUSE_NONE;
            bad_vaddr  <= '0;
        end else begin
            rsp_valid <= take;
            exc_valid <= take && raise_i;
            if (take) begin
                rsp_fault  <= fault_i;
                rsp_mapped <= mapped_i;
                rsp_cached <= cached_i;
                rsp_paddr  <= paddr_i;
                exc_cause  <= raise_i ? cause_i : CAUSE_NONE;
                if (raise_i) bad_vaddr <= va_i;
            end
        end
    end

    // R8: an exception only accompanies a failed response
    p_exc_needs_fault_r8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (rsp_valid && rsp_fault));

    // R7: only the four defined causes are ever raised
    p_cause_legal_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_cause inside {5'd2, 5'd3, 5'd4, 5'd5}));

    // R9: bad address only moves with an exception
    p_bad_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> $stable(bad_vaddr));

    // R2: successful translations are page aligned
    p_page_align_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == '0));

    // R12: failed translations carry no address or attribute
    p_fault_clean_r12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_cached));
endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
    import vsd_pkg::*;
#(
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 12,
    parameter int CCA_LSB   = 59
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            mode64,
    input  logic [63:0]     vaddr,
    input  logic            is_write,
    input  logic            probe_only,
    input  logic            tlb_hit,
    input  logic [PA_W-1:0] tlb_paddr,
    input  logic            tlb_cached,
    output logic            tlb_req,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic            rsp_mapped,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_cached,
    output logic            exc_valid,
    output logic [4:0]      exc_cause,
    output logic [63:0]     bad_vaddr
);
    seg_route_t r32, r64, rt;
    logic       miss, badaddr, fault, raise, cached;
    logic [PA_W-1:0] paddr;
    logic [63:0]     tlb_full;
    cause_e          cause;

    seg_class32 #(.PAGE_BITS(PAGE_BITS)) u_c32 (
        .va(vaddr[31:0]), .route(r32));

    seg_class64 #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W), .CCA_LSB(CCA_LSB)) u_c64 (
        .va(vaddr), .route(r64));

    assign tlb_full = clr_page({{(64-PA_W){1'b0}}, tlb_paddr}, PAGE_BITS);

    always_comb begin
        rt      = mode64 ? r64 : r32;
        miss    = (rt.kind == SEG_MAPPED) && !tlb_hit;
        badaddr = (rt.kind == SEG_BADADDR);
        fault   = miss || badaddr;
        cause   = fault_cause(miss, is_write);
        raise   = fault && !probe_only;
        if (fault) begin
            paddr  = '0;
            cached = 1'b0;
        end else if (rt.kind == SEG_MAPPED) begin
            paddr  = tlb_full[PA_W-1:0];
            cached = tlb_cached;
        end else begin
            paddr  = rt.paddr[PA_W-1:0];
            cached = rt.cached;
        end
    end

    assign tlb_req = req_valid && (rt.kind == SEG_MAPPED);

    seg_outreg #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_out (
        .clk(clk), .rst(rst), .take(req_valid),
        .fault_i(fault), .mapped_i(rt.kind == SEG_MAPPED), .cached_i(cached),
        .paddr_i(paddr), .raise_i(raise), .cause_i(cause), .va_i(vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_mapped(rsp_mapped),
        .rsp_cached(rsp_cached), .rsp_paddr(rsp_paddr), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .bad_vaddr(bad_vaddr));

    // R11: one response per request, one cycle later
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10: probes never raise an exception
    p_probe_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && probe_only) |=> !exc_valid);
endmodule

// File: tb/vaddr_seg_decoder_bench.sv
module vaddr_seg_decoder_bench;
    localparam int PA_W = 36;

    typedef struct packed {
        logic            fault;
        logic            mapped;
        logic            cached;
        logic            exc;
        logic [4:0]      cause;
        logic [PA_W-1:0] pa;
        logic [63:0]     bad;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0, mode64 = 1'b0, is_write = 1'b0, probe_only = 1'b0;
    logic [63:0]     vaddr = '0;
    logic            tlb_hit = 1'b0, tlb_cached = 1'b0;
    logic [PA_W-1:0] tlb_paddr = '0;
    logic            tlb_req, rsp_valid, rsp_fault, rsp_mapped, rsp_cached, exc_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic [4:0]      exc_cause;
    logic [63:0]     bad_vaddr;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [63:0] cur_bad = '0;

    always #10 clk = ~clk;

    vaddr_seg_decoder #(.PA_W(PA_W)) u_vaddr_seg_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode64(mode64), .vaddr(vaddr),
        .is_write(is_write), .probe_only(probe_only), .tlb_hit(tlb_hit),
        .tlb_paddr(tlb_paddr), .tlb_cached(tlb_cached), .tlb_req(tlb_req),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_mapped(rsp_mapped),
        .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .bad_vaddr(bad_vaddr));

    // Independent reference built from the requirements.
    function automatic exp_t model(bit m64, logic [63:0] va, bit wr, bit pr,
                                   bit hit, logic [PA_W-1:0] tpa, bit tc);
        exp_t e;
        bit use_tlb = 0, ae = 0, c = 0;
        logic [PA_W-1:0] p = '0;
        logic [23:0] rg = va[63:40];
        logic [10:0] sz = va[39:29];
        if (!m64) begin
            if (va[31:29] == 3'd4)      begin c = 1; p = {7'd0, va[28:12], 12'h000}; end
            else if (va[31:29] == 3'd5) begin c = 0; p = {7'd0, va[28:12], 12'h000}; end
            else use_tlb = 1;
        end else if (rg inside {24'h000000, 24'h400000, 24'hC00000}) begin
            use_tlb = 1;
        end else if (rg == 24'hFFFFFF) begin
            if (sz == 11'h7FC)      begin c = 1; p = {7'd0, va[28:12], 12'h000}; end
            else if (sz == 11'h7FD) begin c = 0; p = {7'd0, va[28:12], 12'h000}; end
            else if (sz == 11'h7FE || sz == 11'h7FF) use_tlb = 1;
            else ae = 1;
        end else if (rg inside {24'h800000, 24'h880000, 24'h900000, 24'h980000,
                                24'hA00000, 24'hA80000, 24'hB00000, 24'hB80000}) begin
            c = (va[60:59] != 2'd2);
            p = {va[PA_W-1:12], 12'h000};
        end else ae = 1;
        if (use_tlb) begin c = tc; p = {tpa[PA_W-1:12], 12'h000}; end
        e.mapped = use_tlb;
        e.fault  = ae || (use_tlb && !hit);
        if (e.fault) begin c = 0; p = '0; end
        e.cached = c;
        e.pa     = p;
        e.exc    = e.fault && !pr;
        e.cause  = !e.exc ? 5'd0 : ae ? (wr ? 5'd5 : 5'd4) : (wr ? 5'd3 : 5'd2);
        e.bad    = e.exc ? va : cur_bad;
        return e;
    endfunction

    task automatic drive(string tag, bit m64, logic [63:0] va, bit wr, bit pr,
                         bit hit, logic [PA_W-1:0] tpa, bit tc);
        exp_t e;
        @(negedge clk);
        req_valid = 1; mode64 = m64; vaddr = va; is_write = wr; probe_only = pr;
        tlb_hit = hit; tlb_paddr = tpa; tlb_cached = tc;
        e = model(m64, va, wr, pr, hit, tpa, tc);
        cur_bad = e.bad;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        total++;
        if (tlb_req !== e.mapped) begin
            bad++;
            $display("FAIL %s tlb_req va=%h actual=%b expected=%b", tag, va, tlb_req, e.mapped);
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        req_valid = 0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            exp_t  e;
            exp_t  a;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected response actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.fault = rsp_fault; a.mapped = rsp_mapped; a.cached = rsp_cached;
                a.exc = exc_valid; a.cause = exc_cause; a.pa = rsp_paddr; a.bad = bad_vaddr;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s actual f=%b m=%b c=%b x=%b cause=%0d pa=%h bad=%h expected f=%b m=%b c=%b x=%b cause=%0d pa=%h bad=%h",
                        t, a.fault, a.mapped, a.cached, a.exc, a.cause, a.pa, a.bad,
                        e.fault, e.mapped, e.cached, e.exc, e.cause, e.pa, e.bad);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        total++;
        if (rsp_valid !== 0 || exc_valid !== 0 || bad_vaddr !== 64'd0) begin
            bad++;
            $display("FAIL R1 reset actual v=%b x=%b bad=%h expected 0 0 0", rsp_valid, exc_valid, bad_vaddr);
        end

        // 32-bit map
        drive("R3 zone4", 0, 64'h0000_0000_8012_3456, 0, 0, 0, '0, 0);
        drive("R3 zone4 upper ignored (R2)", 0, 64'hDEAD_BEEF_8012_3456, 1, 0, 0, '0, 0);
        drive("R3 zone5", 0, 64'h0000_0000_A765_4321, 0, 0, 1, 36'hF_FFFF_FFFF, 1);
        drive("R2 zone0 hit", 0, 64'h0000_0000_0040_0123, 0, 0, 1, 36'h9_8765_4ABC, 0);
        drive("R2 zone6 hit", 0, 64'hFFFF_FFFF_C000_1000, 1, 0, 1, 36'h1_2345_6FFF, 1);
        drive("R8 zone7 miss store", 0, 64'hFFFF_FFFF_E000_0040, 1, 0, 0, '0, 0);
        drive("R8 zone1 miss load", 0, 64'h0000_0000_2000_0008, 0, 0, 0, '0, 0);
        drive("R9 no exc keeps bad", 0, 64'h0000_0000_8000_0000, 0, 0, 0, '0, 0);
        // 64-bit map
        drive("R4 region0 hit", 1, 64'h0000_0012_3456_7000, 0, 0, 1, 36'h0_AAAA_B123, 1);
        drive("R8 region400000 miss store", 1, 64'h4000_0000_0000_1234, 1, 0, 0, '0, 0);
        drive("R4 regionC00000 hit", 1, 64'hC000_0000_0000_2000, 0, 0, 1, 36'h5_0000_1000, 0);
        drive("R4 sub7FE hit", 1, 64'hFFFF_FFFF_C000_0000, 0, 0, 1, 36'h3_3333_3333, 1);
        drive("R4 sub7FF miss", 1, 64'hFFFF_FFFF_E000_0010, 0, 0, 0, '0, 0);
        drive("R5 sub7FC", 1, 64'hFFFF_FFFF_8123_4567, 0, 0, 0, '0, 0);
        drive("R5 sub7FD", 1, 64'hFFFF_FFFF_A765_4321, 1, 0, 0, '0, 0);
        drive("R7 sub000 load", 1, 64'hFFFF_FF00_0000_0000, 0, 0, 1, '0, 0);
        drive("R7 sub7FB store", 1, 64'hFFFF_FFFF_6000_0000, 1, 0, 1, '0, 0);
        drive("R7 region123456", 1, 64'h1234_5600_0000_0000, 0, 0, 1, '0, 0);
        drive("R6 window attr2 uncached", 1, 64'h9000_000F_ABCD_E123, 0, 0, 0, '0, 0);
        drive("R6 window attr1 mask", 1, 64'hA800_00F1_2345_6789, 0, 0, 0, '0, 0);
        drive("R6 window attr3", 1, 64'hB800_0000_0000_5000, 1, 0, 0, '0, 0);
        drive("R6 window 880000", 1, 64'h8800_0000_0000_5000, 0, 0, 0, '0, 0);
        drive("R7 lookalike 840000", 1, 64'h8400_0000_0000_0000, 1, 0, 0, '0, 0);
        // probes
        drive("R10 probe miss", 0, 64'h0000_0000_0000_3000, 0, 1, 0, '0, 0);
        drive("R10 probe addr error", 1, 64'h7000_0000_0000_0000, 1, 1, 0, '0, 0);
        drive("R10 probe hit", 1, 64'h0000_0000_0000_4000, 0, 1, 1, 36'h0_0000_7000, 1);
        idle(3);

        total++;
        if (rsp_valid !== 0) begin
            bad++;
            $display("FAIL R11 idle actual=%b expected=0", rsp_valid);
        end
        idle(2);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule